// File: doc/BRIEF.md
# Power Mode Controller

This block is the run-state controller of a processor subsystem. Software programs a small control register holding a clock-source bit, a two-bit low-power field and a core power-down bit. From these the block picks one of three operating modes: full-speed run, reduced-speed run and core doze. The block does not divide any clock itself. It tells the clock tree which of two programmed divide factors to apply and whether the core, MMU and cache domain may be clocked. Peripheral and system-interface clocks stay enabled in every mode.

While a low-power mode is active, three wake sources can pull the system back to full-speed run: a pending interrupt, software clearing the power-down bit, and a peripheral service request. The first two share one enable bit and the third has its own. A wake clears the control bits in hardware, so a readback shows the state the hardware has forced. Mode changes take effect at the same clock edge that commits a register write or samples a wake, and every output is registered.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 00 (full-speed), div_sel_o is 0, div_factor_o equals the high-divider reset value (1), core_clk_en_o and periph_clk_en_o are 1, and the control register reads 0.
- R2: Writing the control register (address 0: bit 0 clock-source, bits 2:1 low-power field, bit 3 power-down) with clock-source 1 and field 00 makes mode_o 01, div_sel_o 1 and div_factor_o the low divider at the edge that commits the write.
- R3: Clock-source 0 with field 00 makes mode_o 00, div_sel_o 0 and div_factor_o the high divider (divider register at address 1: bits 3:0 high factor, bits 7:4 low factor).
- R4: Writing the divider register while reduced-speed run is active updates div_factor_o at the edge that commits the write.
- R5: Clock-source 0, field 01 and power-down 1 make mode_o 10, drop core_clk_en_o to 0, keep periph_clk_en_o at 1 and select the high divider.
- R6: In mode 01 or 10, a pending interrupt with the interrupt-wake enable set (address 2, bit 0) returns mode_o to 00 one edge later, and the control register then reads 0.
- R7: In a low-power mode, a control write that clears a set power-down bit, with the interrupt-wake enable set, returns mode_o to 00.
- R8: In a low-power mode, a peripheral request with the peripheral-wake enable set (address 2, bit 1) returns mode_o to 00.
- R9: A wake source whose enable is clear leaves the low-power mode unchanged.
- R10: When a wake and a control write fall in the same cycle, the wake wins: mode_o becomes 00 and the written control value is discarded.
- R11: A low-power field of 10 or 11, or field 01 without clock-source 0 and power-down 1, leaves mode_o unchanged while the written bits are stored.
- R12: The read port returns the addressed register one cycle after rd_addr_i; unused bits and unmapped addresses read 0.
- R13: In full-speed run, wake sources have no effect on the mode or on the stored control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Read data, one cycle after address |
| irq_pend_i | input | 1 | Interrupt pending level |
| periph_req_i | input | 1 | Peripheral service request level |
| mode_o | output | 2 | Current mode: 00 full-speed, 01 reduced-speed, 10 doze |
| div_sel_o | output | 1 | 0 high divider, 1 low divider |
| div_factor_o | output | DIVW | Divide factor for the system clock |
| core_clk_en_o | output | 1 | Core, MMU and cache clock enable |
| periph_clk_en_o | output | 1 | Peripheral and system-interface clock enable |

## Verification
The bench aims at the collision of a wake with a control write: a design that let the write win would land in doze or stay slow with a stale control value readable. It drives reserved and half-matching low-power encodings, where a loose decode would fall into full-speed or doze, and leaves wake sources asserted with their enables clear, which a design ignoring the masks would answer by jumping to full-speed. It also raises wakes in full-speed run, where a design clearing bits unconditionally would wipe the stored control value.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_HIGH = 2'b00,
    PM_LOW  = 2'b01,
    PM_DOZE = 2'b10
  } pm_mode_e;

  localparam logic [1:0] LPF_RUN  = 2'b00;
  localparam logic [1:0] LPF_DOZE = 2'b01;

  localparam int REG_CTL = 0;
  localparam int REG_DIV = 1;
  localparam int REG_WEN = 2;

  localparam int CTL_W = 4;

  typedef struct packed {
    logic       pdn;
    logic [1:0] lpf;
    logic       src;
  } ctl_t;
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 16,
  parameter int DIVW     = 4,
  parameter int DIVH_RST = 1,
  parameter int DIVL_RST = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  input  logic            wake,
  output ctl_t            ctl_nxt,
  output logic [DIVW-1:0] divh_nxt,
  output logic [DIVW-1:0] divl_nxt,
  output logic            irq_en,
  output logic            per_en,
  output logic            sw_clr,
  output logic [DW-1:0]   rd_data
);
  localparam int DIVPAIR = 2 * DIVW;

  ctl_t            ctl_q;
  logic [DIVW-1:0] divh_q, divl_q;
  logic            irq_en_q, per_en_q;
  logic            wr_ctl, wr_div, wr_wen;
  ctl_t            wr_ctl_val;
  logic [DW-1:0]   rd_mux;

  assign wr_ctl     = wr_en && (wr_addr == AW'(REG_CTL));
  assign wr_div     = wr_en && (wr_addr == AW'(REG_DIV));
  assign wr_wen     = wr_en && (wr_addr == AW'(REG_WEN));
  assign wr_ctl_val = ctl_t'(wr_data[CTL_W-1:0]);
  assign sw_clr     = wr_ctl && ctl_q.pdn && !wr_ctl_val.pdn;

  always_comb begin
    ctl_nxt = ctl_q;
    if (wake)        ctl_nxt = '0;
    else if (wr_ctl) ctl_nxt = wr_ctl_val;
  end

  always_comb begin
    divh_nxt = divh_q;
    divl_nxt = divl_q;
    if (wr_div) begin
      divh_nxt = wr_data[DIVW-1:0];
      divl_nxt = wr_data[DIVPAIR-1:DIVW];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == AW'(REG_CTL))      rd_mux[CTL_W-1:0]   = ctl_q;
    else if (rd_addr == AW'(REG_DIV)) rd_mux[DIVPAIR-1:0] = {divl_q, divh_q};
    else if (rd_addr == AW'(REG_WEN)) rd_mux[1:0]         = {per_en_q, irq_en_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      divh_q   <= DIVW'(DIVH_RST);
      divl_q   <= DIVW'(DIVL_RST);
      irq_en_q <= 1'b0;
      per_en_q <= 1'b0;
      rd_data  <= '0;
    end else begin
      ctl_q   <= ctl_nxt;
      divh_q  <= divh_nxt;
      divl_q  <= divl_nxt;
      rd_data <= rd_mux;
      if (wr_wen) begin
        irq_en_q <= wr_data[0];
        per_en_q <= wr_data[1];
      end
    end
  end

  assign irq_en = irq_en_q;
  assign per_en = per_en_q;
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake (
  input  logic in_lp,
  input  logic irq_pend,
  input  logic per_req,
  input  logic sw_clr,
  input  logic irq_en,
  input  logic per_en,
  output logic wake
);
  logic core_evt, per_evt;

  assign core_evt = (irq_pend || sw_clr) && irq_en;
  assign per_evt  = per_req && per_en;
  assign wake     = in_lp && (core_evt || per_evt);
endmodule

// File: rtl/pmc_decode.sv
module pmc_decode
  import pmc_pkg::*;
#(
  parameter int DIVW     = 4,
  parameter int DIVH_RST = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  ctl_t            ctl_nxt,
  input  logic [DIVW-1:0] divh_nxt,
  input  logic [DIVW-1:0] divl_nxt,
  output pm_mode_e        mode_q,
  output logic            div_sel,
  output logic [DIVW-1:0] div_factor,
  output logic            core_en,
  output logic            periph_en
);
  pm_mode_e mode_nxt;

  always_comb begin
    mode_nxt = mode_q;
    if (ctl_nxt.lpf == LPF_RUN)
      mode_nxt = ctl_nxt.src ? PM_LOW : PM_HIGH;
    else if (ctl_nxt.lpf == LPF_DOZE && !ctl_nxt.src && ctl_nxt.pdn)
      mode_nxt = PM_DOZE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= PM_HIGH;
      div_sel    <= 1'b0;
      div_factor <= DIVW'(DIVH_RST);
      core_en    <= 1'b1;
      periph_en  <= 1'b1;
    end else begin
      mode_q     <= mode_nxt;
      div_sel    <= (mode_nxt == PM_LOW);
      div_factor <= (mode_nxt == PM_LOW) ? divl_nxt : divh_nxt;
      core_en    <= (mode_nxt != PM_DOZE);
      periph_en  <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 16,
  parameter int DIVW     = 4,
  parameter int DIVH_RST = 1,
  parameter int DIVL_RST = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  input  logic            irq_pend_i,
  input  logic            periph_req_i,
  output logic [1:0]      mode_o,
  output logic            div_sel_o,
  output logic [DIVW-1:0] div_factor_o,
  output logic            core_clk_en_o,
  output logic            periph_clk_en_o
);
  ctl_t            ctl_nxt;
  logic [DIVW-1:0] divh_nxt, divl_nxt;
  logic            irq_en, per_en, sw_clr, wake;
  pm_mode_e        mode_q;

  pmc_regs #(
    .AW(AW), .DW(DW), .DIVW(DIVW), .DIVH_RST(DIVH_RST), .DIVL_RST(DIVL_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .rd_addr(rd_addr_i), .wake(wake),
    .ctl_nxt(ctl_nxt), .divh_nxt(divh_nxt), .divl_nxt(divl_nxt),
    .irq_en(irq_en), .per_en(per_en), .sw_clr(sw_clr), .rd_data(rd_data_o)
  );

  pmc_wake u_wake (
    .in_lp(mode_q != PM_HIGH), .irq_pend(irq_pend_i), .per_req(periph_req_i),
    .sw_clr(sw_clr), .irq_en(irq_en), .per_en(per_en), .wake(wake)
  );

  pmc_decode #(.DIVW(DIVW), .DIVH_RST(DIVH_RST)) u_dec (
    .clk(clk), .rst(rst),
    .ctl_nxt(ctl_nxt), .divh_nxt(divh_nxt), .divl_nxt(divl_nxt),
    .mode_q(mode_q), .div_sel(div_sel_o), .div_factor(div_factor_o),
    .core_en(core_clk_en_o), .periph_en(periph_clk_en_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic          irq_pend_i,
  input logic          periph_req_i,
  input logic          irq_en,
  input logic          per_en,
  input logic          wake,
  input logic [1:0]    mode_o,
  input logic          div_sel_o,
  input logic          core_clk_en_o,
  input logic          periph_clk_en_o
);
  logic ctl_wr;
  assign ctl_wr = wr_en_i && (wr_addr_i == '0);

  a_r2_low_div_select: assert property (@(posedge clk) disable iff (rst)
    div_sel_o == (mode_o == 2'b01));

  a_r5_doze_gates_core: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b10) |-> (!core_clk_en_o && periph_clk_en_o));

  a_r5_run_core_on: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'b10) |-> core_clk_en_o);

  a_r6_irq_wake: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'b00 && irq_pend_i && irq_en) |=> (mode_o == 2'b00));

  a_r8_periph_wake: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'b00 && periph_req_i && per_en) |=> (mode_o == 2'b00));

  a_r9_masked_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b01 && !wr_en_i && !(irq_pend_i && irq_en) && !(periph_req_i && per_en))
      |=> (mode_o == 2'b01));

  a_r11_reserved_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data_i[2] && !wake) |=> (mode_o == $past(mode_o)));

  a_r13_high_stays: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00 && !ctl_wr) |=> (mode_o == 2'b00));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .irq_pend_i(irq_pend_i), .periph_req_i(periph_req_i),
  .irq_en(irq_en), .per_en(per_en), .wake(wake), .mode_o(mode_o),
  .div_sel_o(div_sel_o), .core_clk_en_o(core_clk_en_o),
  .periph_clk_en_o(periph_clk_en_o)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DIVW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en_i = 1'b0;
  logic [AW-1:0]   wr_addr_i = '0;
  logic [DW-1:0]   wr_data_i = '0;
  logic [AW-1:0]   rd_addr_i = '0;
  logic [DW-1:0]   rd_data_o;
  logic            irq_pend_i = 1'b0;
  logic            periph_req_i = 1'b0;
  logic [1:0]      mode_o;
  logic            div_sel_o;
  logic [DIVW-1:0] div_factor_o;
  logic            core_clk_en_o;
  logic            periph_clk_en_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.AW(AW), .DW(DW), .DIVW(DIVW)) dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .irq_pend_i(irq_pend_i), .periph_req_i(periph_req_i), .mode_o(mode_o),
    .div_sel_o(div_sel_o), .div_factor_o(div_factor_o),
    .core_clk_en_o(core_clk_en_o), .periph_clk_en_o(periph_clk_en_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_addr_i = AW'(addr);
    wr_data_i = DW'(data);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(int addr, output int val);
    @(negedge clk);
    rd_addr_i = AW'(addr);
    @(negedge clk);
    val = int'(rd_data_o);
  endtask

  task automatic chk_mode(string req, int m);
    chk(req, "mode", int'(mode_o), m);
  endtask

  task automatic t_reset();
    int v;
    chk("R1", "mode", int'(mode_o), 0);
    chk("R1", "div_sel", int'(div_sel_o), 0);
    chk("R1", "div_factor", int'(div_factor_o), 1);
    chk("R1", "core_en", int'(core_clk_en_o), 1);
    chk("R1", "periph_en", int'(periph_clk_en_o), 1);
    rd(0, v);
    chk("R1", "ctl readback", v, 0);
  endtask

  task automatic t_speeds();
    wr(1, 'h62);
    chk("R3", "div_factor high", int'(div_factor_o), 2);
    wr(0, 'h1);
    chk_mode("R2", 1);
    chk("R2", "div_sel", int'(div_sel_o), 1);
    chk("R2", "div_factor low", int'(div_factor_o), 6);
    wr(1, 'h92);
    chk("R4", "div_factor live", int'(div_factor_o), 9);
    wr(0, 'h0);
    chk_mode("R3", 0);
    chk("R3", "div_sel", int'(div_sel_o), 0);
    chk("R3", "div_factor", int'(div_factor_o), 2);
  endtask

  task automatic t_doze_irq();
    int v;
    wr(0, 'hA);
    chk_mode("R5", 2);
    chk("R5", "core_en", int'(core_clk_en_o), 0);
    chk("R5", "periph_en", int'(periph_clk_en_o), 1);
    chk("R5", "div_factor", int'(div_factor_o), 2);
    @(negedge clk);
    irq_pend_i = 1'b1;
    repeat (3) @(negedge clk);
    chk_mode("R9", 2);
    wr(2, 'h1);
    @(negedge clk);
    chk_mode("R6", 0);
    chk("R6", "core_en", int'(core_clk_en_o), 1);
    irq_pend_i = 1'b0;
    rd(0, v);
    chk("R6", "ctl cleared", v, 0);
  endtask

  task automatic t_periph();
    int v;
    wr(2, 'h2);
    wr(0, 'h1);
    chk_mode("R2", 1);
    @(negedge clk);
    irq_pend_i = 1'b1;
    repeat (2) @(negedge clk);
    chk_mode("R9", 1);
    irq_pend_i = 1'b0;
    periph_req_i = 1'b1;
    @(negedge clk);
    chk_mode("R8", 0);
    periph_req_i = 1'b0;
    rd(0, v);
    chk("R8", "ctl cleared", v, 0);
  endtask

  task automatic t_sw();
    int v;
    wr(2, 'h1);
    wr(0, 'h9);
    chk_mode("R7", 1);
    wr(0, 'h1);
    chk_mode("R7", 0);
    rd(0, v);
    chk("R10", "sw wake drops write", v, 0);
  endtask

  task automatic t_race();
    int v;
    wr(0, 'h1);
    chk_mode("R10", 1);
    @(negedge clk);
    irq_pend_i = 1'b1;
    wr_en_i = 1'b1;
    wr_addr_i = '0;
    wr_data_i = DW'('hA);
    @(negedge clk);
    wr_en_i = 1'b0;
    irq_pend_i = 1'b0;
    chk_mode("R10", 0);
    chk("R10", "core_en", int'(core_clk_en_o), 1);
    rd(0, v);
    chk("R10", "ctl discarded", v, 0);
  endtask

  task automatic t_reserved();
    int v;
    wr(2, 'h0);
    wr(0, 'h1);
    wr(0, 'h5);
    chk_mode("R11", 1);
    chk("R11", "div_sel", int'(div_sel_o), 1);
    rd(0, v);
    chk("R12", "ctl stored", v, 5);
    wr(0, 'h7);
    chk_mode("R11", 1);
    wr(0, 'h2);
    chk_mode("R11", 1);
    wr(0, 'h0);
    chk_mode("R3", 0);
    wr(0, 'h3);
    chk_mode("R11", 0);
  endtask

  task automatic t_high_events();
    int v;
    wr(2, 'h3);
    wr(0, 'h6);
    chk_mode("R13", 0);
    @(negedge clk);
    irq_pend_i = 1'b1;
    periph_req_i = 1'b1;
    repeat (2) @(negedge clk);
    chk_mode("R13", 0);
    irq_pend_i = 1'b0;
    periph_req_i = 1'b0;
    rd(0, v);
    chk("R13", "ctl kept", v, 6);
    wr(0, 'h0);
  endtask

  task automatic t_readback();
    int v;
    rd(1, v);
    chk("R12", "div reg", v, 'h92);
    rd(2, v);
    chk("R12", "wen reg", v, 3);
    rd(5, v);
    chk("R12", "unmapped", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_speeds();
    t_doze_irq();
    t_periph();
    t_sw();
    t_race();
    t_reserved();
    t_high_events();
    t_readback();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule